// File: doc/BRIEF.md
# Multi-Core Interrupt Handoff Tracker

This block sits on the interrupt-controller side of a multi-core system. It keeps a pool of pending interrupt lines, each with a configured priority. It picks the most urgent line that no core is already handling and offers it to a core that can take it. A core may take an interrupt when it is idle, or when it is servicing something of strictly lower priority. Each core has its own handshake state machine, so a handoff that stalls for hundreds of cycles on one core never holds up offers to the others.

The handoff has two phases. The core first answers an offer with an immediate ACK, which means it may take the interrupt, or with a NAK. After an ACK, the core later sends either ACCEPT, which completes the handoff, or REJECT, for example when a pipeline flush has turned interrupts off again. An offered line is reserved so that no second core sees it at the same time. A NAK or a REJECT releases the reservation, and the line becomes eligible again. An ACCEPT removes the line from the pending pool and raises the core's running priority. An end-of-interrupt strobe from the core clears that running priority.

Per-core states and transitions. The encoding is the value on `core_state`.
- IDLE (0): the core runs nothing. A grant moves it to REQ.
- REQ (1): an offer is outstanding and `req_valid` is high. NAK returns the core; ACK moves it to WAIT_FINAL.
- WAIT_FINAL (2): the core has acknowledged. ACCEPT moves it to COMPLETE; REJECT returns the core.
- COMPLETE (3): the core services an interrupt. EOI moves it to IDLE; a grant of a higher priority line moves it to REQ.
- "Returns the core" means the core goes to COMPLETE if its running priority is non-zero, and to IDLE otherwise.

Top module: `irq_handoff_tracker`

## Requirements
- R1: After reset every core is IDLE (0), `req_valid` is all zero, every `core_prio` is 0 and `irq_pending` is all zero.
- R2: A pulse on `irq_raise[i]` sets `irq_pending[i]` at the next edge. An ACCEPT clears the pending bit of the accepted line. If a raise of the same line arrives in the same cycle as that ACCEPT, the bit stays set.
- R3: The candidate line has the highest priority among the pending, unreserved lines. Equal priorities go to the lowest index. A line with priority 0 is never offered.
- R4: An offer goes to the lowest-indexed core that is IDLE, or COMPLETE without EOI in that cycle, and whose running priority is strictly below the candidate's priority. At most one offer is made per cycle. The offered core shows REQ (1), `req_valid` high and the line number on `req_id` after the next edge.
- R5: A line held by a core in REQ or WAIT_FINAL is not offered to any other core.
- R6: In REQ, a NAK returns the core and frees the line. Otherwise an ACK moves the core to WAIT_FINAL (2) and drops `req_valid`. NAK wins when both are high.
- R7: In WAIT_FINAL, an ACCEPT moves the core to COMPLETE (3) and sets `core_prio` to the offered line's priority. Otherwise a REJECT returns the core and leaves the line pending and eligible. ACCEPT wins when both are high.
- R8: In COMPLETE, EOI moves the core to IDLE and clears `core_prio`. EOI in any other state has no effect.
- R9: ACK and NAK outside REQ, and ACCEPT and REJECT outside WAIT_FINAL, have no effect.
- R10: A core waiting in REQ or WAIT_FINAL does not prevent offers to other free cores.
- R11: A core in COMPLETE may be offered a line of higher priority than its own; a NAK or REJECT of that offer puts it back in COMPLETE with its running priority unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_raise | input | NUM_IRQS | One-cycle raise strobe per interrupt line |
| irq_prio | input | NUM_IRQS x PRIO_W | Configured priority per line, 0 = masked |
| core_ack | input | NUM_CORES | Immediate acknowledge per core |
| core_nak | input | NUM_CORES | Immediate refusal per core |
| core_accept | input | NUM_CORES | Final acceptance per core |
| core_reject | input | NUM_CORES | Final withdrawal per core |
| core_eoi | input | NUM_CORES | End of interrupt service per core |
| req_valid | output | NUM_CORES | Offer outstanding (state REQ) |
| req_id | output | NUM_CORES x ID_W | Line held by each core in REQ or WAIT_FINAL |
| core_state | output | NUM_CORES x 2 | Handshake state per core |
| core_prio | output | NUM_CORES x PRIO_W | Running priority per core |
| irq_pending | output | NUM_IRQS | Pending pool |

## Verification
Several events can land on the same edge. The most delicate pair is an ACCEPT that clears a line's pending bit while a fresh raise of that same line sets it again. The other is a REJECT or NAK on one core that frees a line while a different line is being granted to another core. The directed part drives an ACCEPT and a raise of the same line on one edge and expects the pending bit to remain set. The random part lets replies, raises and EOIs collide freely, and a bench model updates pending, reservation and per-core state from the requirements and compares them every cycle.

// File: rtl/ihand_pkg.sv
package ihand_pkg;

    typedef enum logic [1:0] {
        HS_IDLE       = 2'd0,
        HS_REQ        = 2'd1,
        HS_WAIT_FINAL = 2'd2,
        HS_COMPLETE   = 2'd3
    } hs_state_t;

endpackage

// File: rtl/ihand_prio_select.sv
module ihand_prio_select #(
    parameter int NUM_IRQS = 8,
    parameter int PRIO_W   = 3,
    parameter int ID_W     = 3
) (
    input  logic [NUM_IRQS-1:0]             elig,
    input  logic [NUM_IRQS-1:0][PRIO_W-1:0] prio,
    output logic                            found,
    output logic [ID_W-1:0]                 best_id,
    output logic [PRIO_W-1:0]               best_prio
);

    // Strict comparison while scanning upward keeps the lowest index on ties
    // and never selects a priority-0 line.
    always_comb begin
        best_id   = '0;
        best_prio = '0;
        for (int i = 0; i < NUM_IRQS; i++) begin
            if (elig[i] && (prio[i] > best_prio)) begin
                best_id   = ID_W'(i);
                best_prio = prio[i];
            end
        end
        found = (best_prio != '0);
    end

endmodule

// File: rtl/ihand_core_pick.sv
module ihand_core_pick #(
    parameter int NUM_CORES = 4,
    parameter int PRIO_W    = 3
) (
    input  logic                             offer_valid,
    input  logic [PRIO_W-1:0]                offer_prio,
    input  logic [NUM_CORES-1:0]             free,
    input  logic [NUM_CORES-1:0][PRIO_W-1:0] cur_prio,
    output logic [NUM_CORES-1:0]             grant
);

    logic [NUM_CORES-1:0] able;

    always_comb begin
        for (int c = 0; c < NUM_CORES; c++) begin
            able[c] = offer_valid && free[c] && (cur_prio[c] < offer_prio);
        end
    end

    always_comb begin
        grant = '0;
        for (int c = NUM_CORES - 1; c >= 0; c--) begin
            if (able[c]) begin
                grant    = '0;
                grant[c] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ihand_irq_pool.sv
module ihand_irq_pool #(
    parameter int NUM_IRQS  = 8,
    parameter int NUM_CORES = 4,
    parameter int ID_W      = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_IRQS-1:0]            raise,
    input  logic                           grant_en,
    input  logic [ID_W-1:0]                grant_id,
    input  logic [NUM_CORES-1:0]           rel,
    input  logic [NUM_CORES-1:0]           acc,
    input  logic [NUM_CORES-1:0][ID_W-1:0] slot_id,
    output logic [NUM_IRQS-1:0]            pending,
    output logic [NUM_IRQS-1:0]            reserved
);

    logic [NUM_IRQS-1:0] clr_pend;
    logic [NUM_IRQS-1:0] clr_resv;
    logic [NUM_IRQS-1:0] set_resv;

    always_comb begin
        clr_pend = '0;
        clr_resv = '0;
        set_resv = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (acc[c]) begin
                clr_pend[slot_id[c]] = 1'b1;
                clr_resv[slot_id[c]] = 1'b1;
            end
            if (rel[c]) begin
                clr_resv[slot_id[c]] = 1'b1;
            end
        end
        if (grant_en) begin
            set_resv[grant_id] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= '0;
            reserved <= '0;
        end else begin
            pending  <= (pending & ~clr_pend) | raise;
            reserved <= (reserved & ~clr_resv) | set_resv;
        end
    end

    // R5
    resv_implies_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reserved & ~pending) == '0);

    // R2
    raise_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raise != '0) |=> ((pending & $past(raise)) == $past(raise)));

endmodule

// File: rtl/ihand_core_fsm.sv
module ihand_core_fsm
    import ihand_pkg::*;
#(
    parameter int PRIO_W = 3,
    parameter int ID_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    input  logic [ID_W-1:0]   grant_id,
    input  logic [PRIO_W-1:0] grant_prio,
    input  logic              ack,
    input  logic              nak,
    input  logic              accept,
    input  logic              reject,
    input  logic              eoi,
    output hs_state_t         state,
    output logic [ID_W-1:0]   slot_id,
    output logic [PRIO_W-1:0] cur_prio,
    output logic              free,
    output logic              release_o,
    output logic              accept_o,
    output logic              req_valid,
    output logic              busy
);

    hs_state_t         st_q;
    hs_state_t         st_d;
    hs_state_t         back_st;
    logic [ID_W-1:0]   id_q;
    logic [PRIO_W-1:0] offer_q;
    logic [PRIO_W-1:0] cur_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= HS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions
    always_comb begin
        back_st = (cur_q != '0) ? HS_COMPLETE : HS_IDLE;
        st_d    = st_q;
        unique case (st_q)
            HS_IDLE: begin
                if (grant) st_d = HS_REQ;
            end
            HS_REQ: begin
                if (nak)      st_d = back_st;
                else if (ack) st_d = HS_WAIT_FINAL;
            end
            HS_WAIT_FINAL: begin
                if (accept)      st_d = HS_COMPLETE;
                else if (reject) st_d = back_st;
            end
            HS_COMPLETE: begin
                if (eoi)        st_d = HS_IDLE;
                else if (grant) st_d = HS_REQ;
            end
            default: st_d = HS_IDLE;
        endcase
    end

    // offer slot and running priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q    <= '0;
            offer_q <= '0;
            cur_q   <= '0;
        end else begin
            if (grant && (st_q == HS_IDLE || (st_q == HS_COMPLETE && !eoi))) begin
                id_q    <= grant_id;
                offer_q <= grant_prio;
            end
            if (st_q == HS_WAIT_FINAL && accept) begin
                cur_q <= offer_q;
            end else if (st_q == HS_COMPLETE && eoi) begin
                cur_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        state     = st_q;
        slot_id   = id_q;
        cur_prio  = cur_q;
        free      = (st_q == HS_IDLE) || (st_q == HS_COMPLETE && !eoi);
        release_o = (st_q == HS_REQ && nak) ||
                    (st_q == HS_WAIT_FINAL && reject && !accept);
        accept_o  = (st_q == HS_WAIT_FINAL) && accept;
        req_valid = (st_q == HS_REQ);
        busy      = (st_q == HS_REQ) || (st_q == HS_WAIT_FINAL);
    end

    // R7
    complete_prio_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HS_COMPLETE) |-> (cur_q != '0));

    // R6
    wait_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HS_WAIT_FINAL) |-> $past(st_q == HS_REQ || st_q == HS_WAIT_FINAL));

    // R8
    eoi_clears_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HS_COMPLETE && eoi) |=> (cur_q == '0 && st_q == HS_IDLE));

    // R4
    grant_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (st_q == HS_IDLE || st_q == HS_COMPLETE));

    // R11
    busy_keeps_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HS_REQ) |=> $stable(cur_q));

endmodule

// File: rtl/irq_handoff_tracker.sv
module irq_handoff_tracker
    import ihand_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_IRQS  = 8,
    parameter int PRIO_W    = 3,
    localparam int ID_W     = (NUM_IRQS > 1) ? $clog2(NUM_IRQS) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_IRQS-1:0]              irq_raise,
    input  logic [NUM_IRQS-1:0][PRIO_W-1:0]  irq_prio,
    input  logic [NUM_CORES-1:0]             core_ack,
    input  logic [NUM_CORES-1:0]             core_nak,
    input  logic [NUM_CORES-1:0]             core_accept,
    input  logic [NUM_CORES-1:0]             core_reject,
    input  logic [NUM_CORES-1:0]             core_eoi,
    output logic [NUM_CORES-1:0]             req_valid,
    output logic [NUM_CORES-1:0][ID_W-1:0]   req_id,
    output logic [NUM_CORES-1:0][1:0]        core_state,
    output logic [NUM_CORES-1:0][PRIO_W-1:0] core_prio,
    output logic [NUM_IRQS-1:0]              irq_pending
);

    logic [NUM_IRQS-1:0]              pending;
    logic [NUM_IRQS-1:0]              reserved;
    logic                             cand_found;
    logic [ID_W-1:0]                  cand_id;
    logic [PRIO_W-1:0]                cand_prio;
    logic [NUM_CORES-1:0]             grant;
    logic [NUM_CORES-1:0]             free;
    logic [NUM_CORES-1:0]             rel;
    logic [NUM_CORES-1:0]             acc;
    logic [NUM_CORES-1:0]             busy;
    logic [NUM_CORES-1:0][ID_W-1:0]   slot_id;
    logic [NUM_CORES-1:0][PRIO_W-1:0] cur_prio;
    hs_state_t                        st [NUM_CORES];

    ihand_prio_select #(
        .NUM_IRQS (NUM_IRQS),
        .PRIO_W   (PRIO_W),
        .ID_W     (ID_W)
    ) u_select (
        .elig      (pending & ~reserved),
        .prio      (irq_prio),
        .found     (cand_found),
        .best_id   (cand_id),
        .best_prio (cand_prio)
    );

    ihand_core_pick #(
        .NUM_CORES (NUM_CORES),
        .PRIO_W    (PRIO_W)
    ) u_pick (
        .offer_valid (cand_found),
        .offer_prio  (cand_prio),
        .free        (free),
        .cur_prio    (cur_prio),
        .grant       (grant)
    );

    ihand_irq_pool #(
        .NUM_IRQS  (NUM_IRQS),
        .NUM_CORES (NUM_CORES),
        .ID_W      (ID_W)
    ) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .raise    (irq_raise),
        .grant_en (|grant),
        .grant_id (cand_id),
        .rel      (rel),
        .acc      (acc),
        .slot_id  (slot_id),
        .pending  (pending),
        .reserved (reserved)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        ihand_core_fsm #(
            .PRIO_W (PRIO_W),
            .ID_W   (ID_W)
        ) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .grant      (grant[c]),
            .grant_id   (cand_id),
            .grant_prio (cand_prio),
            .ack        (core_ack[c]),
            .nak        (core_nak[c]),
            .accept     (core_accept[c]),
            .reject     (core_reject[c]),
            .eoi        (core_eoi[c]),
            .state      (st[c]),
            .slot_id    (slot_id[c]),
            .cur_prio   (cur_prio[c]),
            .free       (free[c]),
            .release_o  (rel[c]),
            .accept_o   (acc[c]),
            .req_valid  (req_valid[c]),
            .busy       (busy[c])
        );

        assign core_state[c] = st[c];

        for (genvar d = c + 1; d < NUM_CORES; d++) begin : g_pair
            // R5
            unique_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (busy[c] && busy[d]) |-> (slot_id[c] != slot_id[d]));
        end
    end

    assign req_id      = slot_id;
    assign core_prio   = cur_prio;
    assign irq_pending = pending;

    // R4
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R3
    grant_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> (cand_prio != '0 && pending[cand_id] && !reserved[cand_id]));

endmodule

// File: tb/irq_handoff_tracker_test.sv
module irq_handoff_tracker_test;

    localparam int CLK_PERIOD = 10;
    localparam int NC  = 4;
    localparam int NI  = 8;
    localparam int PW  = 3;
    localparam int IDW = 3;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NI-1:0]           irq_raise = '0;
    logic [NI-1:0][PW-1:0]   irq_prio;
    logic [NC-1:0]           core_ack = '0, core_nak = '0, core_accept = '0;
    logic [NC-1:0]           core_reject = '0, core_eoi = '0;
    logic [NC-1:0]           req_valid;
    logic [NC-1:0][IDW-1:0]  req_id;
    logic [NC-1:0][1:0]      core_state;
    logic [NC-1:0][PW-1:0]   core_prio;
    logic [NI-1:0]           irq_pending;

    int checks = 0;
    int failures = 0;

    // bench model
    int m_st [NC];
    int m_id [NC];
    int m_op [NC];
    int m_cp [NC];
    bit [NI-1:0] m_pend;
    bit [NI-1:0] m_res;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_handoff_tracker #(.NUM_CORES(NC), .NUM_IRQS(NI), .PRIO_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .irq_raise(irq_raise), .irq_prio(irq_prio),
        .core_ack(core_ack), .core_nak(core_nak), .core_accept(core_accept),
        .core_reject(core_reject), .core_eoi(core_eoi), .req_valid(req_valid),
        .req_id(req_id), .core_state(core_state), .core_prio(core_prio),
        .irq_pending(irq_pending)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int back_state(input int c);
        return (m_cp[c] != 0) ? 3 : 0;
    endfunction

    task automatic model_advance(input bit [NI-1:0] r, input bit [NC-1:0] a, input bit [NC-1:0] n,
                                 input bit [NC-1:0] ac, input bit [NC-1:0] rj, input bit [NC-1:0] e);
        int bp = 0;
        int bi = 0;
        int gc = -1;
        bit [NI-1:0] clr_p = '0;
        bit [NI-1:0] clr_r = '0;
        bit [NI-1:0] set_r = '0;
        for (int i = 0; i < NI; i++) begin
            if (m_pend[i] && !m_res[i] && int'(irq_prio[i]) > bp) begin
                bp = int'(irq_prio[i]);
                bi = i;
            end
        end
        if (bp > 0) begin
            for (int c = 0; c < NC; c++) begin
                if (gc < 0 && (m_st[c] == 0 || (m_st[c] == 3 && !e[c])) && m_cp[c] < bp) gc = c;
            end
        end
        for (int c = 0; c < NC; c++) begin
            case (m_st[c])
                0: if (c == gc) begin m_st[c] = 1; m_id[c] = bi; m_op[c] = bp; end
                1: if (n[c]) begin m_st[c] = back_state(c); clr_r[m_id[c]] = 1'b1; end
                   else if (a[c]) m_st[c] = 2;
                2: if (ac[c]) begin
                       m_st[c] = 3; m_cp[c] = m_op[c];
                       clr_p[m_id[c]] = 1'b1; clr_r[m_id[c]] = 1'b1;
                   end else if (rj[c]) begin
                       m_st[c] = back_state(c); clr_r[m_id[c]] = 1'b1;
                   end
                default: if (e[c]) begin m_st[c] = 0; m_cp[c] = 0; end
                   else if (c == gc) begin m_st[c] = 1; m_id[c] = bi; m_op[c] = bp; end
            endcase
        end
        if (gc >= 0) set_r[bi] = 1'b1;
        m_pend = (m_pend & ~clr_p) | r;
        m_res  = (m_res & ~clr_r) | set_r;
    endtask

    task automatic compare_all();
        for (int c = 0; c < NC; c++) begin
            chk(int'(core_state[c]) == m_st[c], $sformatf("R6 R7 R8 R9 state core%0d", c),
                int'(core_state[c]), m_st[c]);
            chk(int'(core_prio[c]) == m_cp[c], $sformatf("R7 R11 prio core%0d", c),
                int'(core_prio[c]), m_cp[c]);
            chk(req_valid[c] == (m_st[c] == 1), $sformatf("R4 req_valid core%0d", c),
                int'(req_valid[c]), int'(m_st[c] == 1));
            if (m_st[c] == 1 || m_st[c] == 2)
                chk(int'(req_id[c]) == m_id[c], $sformatf("R3 R5 id core%0d", c),
                    int'(req_id[c]), m_id[c]);
        end
        chk(irq_pending == m_pend, "R2 pending", int'(irq_pending), int'(m_pend));
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input bit [NI-1:0] r, input bit [NC-1:0] a, input bit [NC-1:0] n,
                        input bit [NC-1:0] ac, input bit [NC-1:0] rj, input bit [NC-1:0] e);
        irq_raise = r; core_ack = a; core_nak = n;
        core_accept = ac; core_reject = rj; core_eoi = e;
        model_advance(r, a, n, ac, rj, e);
        @(posedge clk);
        @(negedge clk);
        irq_raise = '0; core_ack = '0; core_nak = '0;
        core_accept = '0; core_reject = '0; core_eoi = '0;
        compare_all();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        irq_prio = {3'd7, 3'd2, 3'd0, 3'd7, 3'd1, 3'd5, 3'd5, 3'd3};
        for (int c = 0; c < NC; c++) begin m_st[c] = 0; m_id[c] = 0; m_op[c] = 0; m_cp[c] = 0; end
        m_pend = '0; m_res = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(core_state == '0, "R1 states", int'(core_state), 0);
        chk(req_valid == '0, "R1 req_valid", int'(req_valid), 0);
        chk(core_prio == '0, "R1 prio", int'(core_prio), 0);
        chk(irq_pending == '0, "R1 pending", int'(irq_pending), 0);

        step(8'b0000_0110, '0, '0, '0, '0, '0);
        step('0, '0, '0, '0, '0, '0);
        chk(core_state[0] == 2'd1 && req_id[0] == 3'd1, "R3 tie to lowest index", int'(req_id[0]), 1);
        step('0, '0, '0, '0, '0, '0);
        chk(core_state[1] == 2'd1, "R4 one offer per cycle", int'(core_state[1]), 1);
        chk(req_id[1] == 3'd2, "R5 reserved line not reoffered", int'(req_id[1]), 2);
        step('0, 4'b0001, 4'b0010, '0, '0, '0);
        chk(core_state[0] == 2'd2 && !req_valid[0], "R6 ack to wait", int'(core_state[0]), 2);
        chk(core_state[1] == 2'd0, "R6 nak to idle", int'(core_state[1]), 0);
        step('0, '0, '0, '0, '0, '0);
        chk(core_state[1] == 2'd1 && req_id[1] == 3'd2, "R10 offer while core0 waits",
            int'(req_id[1]), 2);
        step(8'b0000_0010, '0, '0, 4'b0001, '0, '0);
        chk(irq_pending[1] == 1'b1, "R2 raise beats accept clear", int'(irq_pending[1]), 1);
        chk(core_state[0] == 2'd3 && core_prio[0] == 3'd5, "R7 accept sets prio",
            int'(core_prio[0]), 5);
        step('0, '0, '0, '0, '0, 4'b0010);
        chk(core_state[1] == 2'd1, "R8 eoi ignored in REQ", int'(core_state[1]), 1);
        chk(core_state[2] == 2'd1 && req_id[2] == 3'd1, "R4 next free core", int'(req_id[2]), 1);
        step(8'b0001_0000, '0, '0, '0, '0, '0);
        step('0, '0, '0, '0, '0, '0);
        chk(core_state[0] == 2'd1 && req_id[0] == 3'd4 && core_prio[0] == 3'd5,
            "R11 nested offer", int'(req_id[0]), 4);
        step('0, 4'b0001, '0, '0, '0, '0);
        step('0, '0, '0, 4'b0100, 4'b0001, '0);
        chk(core_state[0] == 2'd3 && core_prio[0] == 3'd5, "R11 reject keeps running prio",
            int'(core_prio[0]), 5);
        chk(irq_pending[4] == 1'b1, "R7 reject keeps line pending", int'(irq_pending[4]), 1);
        chk(core_state[2] == 2'd1, "R9 stray accept ignored", int'(core_state[2]), 1);

        for (int k = 0; k < 4000; k++) begin
            bit [NI-1:0] r;
            bit [NC-1:0] a, n, ac, rj, e;
            for (int i = 0; i < NI; i++) r[i] = ($urandom % 20) == 0;
            for (int c = 0; c < NC; c++) begin
                a[c]  = ($urandom % 4) == 0;
                n[c]  = ($urandom % 8) == 0;
                ac[c] = ($urandom % 12) == 0;
                rj[c] = ($urandom % 14) == 0;
                e[c]  = ($urandom % 16) == 0;
            end
            step(r, a, n, ac, rj, e);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule